// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a small on-chip synchronous SRAM whose bus never needs an idle cycle when it turns from reads to writes. It samples commands, addresses and byte strobes on rising clock edges. Write data follows its address by a fixed delay (late write), so a read and a write can be issued on consecutive edges. A static mode pin selects one of two timings. In flow-through timing, read data comes straight from the array, and write data is due one edge after its address. In pipelined timing, read data passes through an output register, and write data is due two edges after its address.

Each command is either a load or an advance. A load starts a read or a write at a new address. An advance repeats the previous command type at the next address of a four-beat burst, in linear or interleaved order. Three chip enables provide depth expansion. Each 9-bit byte has its own active-low write strobe. Output enable and sleep turn the data outputs off asynchronously. The data bus is split into an input vector, an output vector and an output-enable flag, ready for a pad or tri-state wrapper.

The burst controller holds the command state of the current cycle. It has four states: `ST_DESEL` (nothing selected), `ST_READ`, `ST_WRITE` and `ST_SLEEP`. Enabled edges move it through these transitions:
- SLEEP_IN: any state goes to `ST_SLEEP` whenever sleep is high at the edge.
- LOAD_RD: a selected load with `wr_n`=1 goes to `ST_READ`.
- LOAD_WR: a selected load with `wr_n`=0 goes to `ST_WRITE`.
- DESELECT: an unselected load goes to `ST_DESEL`.
- ADVANCE: from `ST_READ` or `ST_WRITE`, the state stays the same. From `ST_DESEL` or `ST_SLEEP`, it goes to `ST_DESEL`.

Top module: `nbt_sram`

## Requirements
- R1: A load (`adv`=0) is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. Any other combination deselects: the load produces no read output and writes nothing.
- R2: A selected load with `wr_n`=1 starts a read of `addr`. With `wr_n`=0 it starts a write of `addr`. Commands, addresses and strobes are sampled on rising edges where `clk_en`=1.
- R3: With `pipe_mode`=0, data for a read issued at edge c is driven (`dq_oe`=1) from edge c until edge c+1.
- R4: With `pipe_mode`=1, data for a read issued at edge c is driven from edge c+1 until edge c+2, through an output register.
- R5: Write data on `dq_in` is sampled at the first enabled edge after the address when `pipe_mode`=0, and at the second enabled edge after it when `pipe_mode`=1.
- R6: Byte i is bits [9i+8:9i]. A write changes byte i only when `bw_n[i]`=0. The strobes are sampled with the address, not with the data.
- R7: Reads and writes may alternate on every edge. A read always returns the data of all writes issued before it, including a write whose data has not yet been sampled, merged byte by byte.
- R8: An advance (`adv`=1) repeats the previous read or write at the next burst address. The upper address bits stay fixed. The low two bits are (base + n) mod 4 when `burst_lin`=1, and base XOR n when `burst_lin`=0, for beat n. An advance after a deselect or after sleep is a deselect.
- R9: An edge with `clk_en`=0 is ignored. The state, the burst position, the outputs and any pending write data all hold.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.
- R11: `sleep`=1 forces `dq_oe` to 0 at once. Edges with sleep high start no command, an advance right after sleep is a deselect, and stored data is kept.
- R12: After reset, `dq_oe` is 0 and the controller is in `ST_DESEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| clk_en | input | 1 | Clock enable; 0 makes an edge a no-op |
| addr | input | AW | Word address for a load |
| adv | input | 1 | 1 = advance burst, 0 = load new command |
| wr_n | input | 1 | Load type: 1 read, 0 write |
| bw_n | input | NB | Active-low byte write strobes |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| pipe_mode | input | 1 | 1 pipelined, 0 flow-through (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dq_in | input | NB*9 | Write data from the bus |
| dq_out | output | NB*9 | Read data to the bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The bench builds the block with AW=4 and NB=2, giving a 16-word array of two 9-bit bytes. At that size it can write and read back every word in both timing modes. It also sweeps all four byte-strobe patterns, all eight chip-enable combinations, and every burst start offset in both burst orders.

The bench checks the output on every cycle against a sequential model in which each read sees all earlier writes. This model covers the pending-write forwarding case in pipelined mode. It also covers clock-enable stalls, which are placed between a write address and its data.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    // Command state of the current cycle, held by the burst controller.
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } nbt_state_e;

    // Low two address bits of burst beat n for a given start offset.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       lin);
        logic [1:0] r;
        if (lin) r = start + beat;
        else     r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/nbt_burst_fsm.sv
module nbt_burst_fsm
    import nbt_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          sleep,
    input  logic          adv,
    input  logic          wr_n,
    input  logic          sel,
    input  logic          burst_lin,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bw_n,
    output nbt_state_e    state,
    output logic [AW-1:0] cur_addr,
    output logic [NB-1:0] cur_bw_n
);

    nbt_state_e    nxt;
    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [NB-1:0] bw_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_DESEL;
        else if (clk_en) state <= nxt;
    end

    // Transitions: SLEEP_IN, ADVANCE, LOAD_RD, LOAD_WR, DESELECT.
    always_comb begin
        nxt = state;
        if (sleep) begin
            nxt = ST_SLEEP;
        end else if (adv) begin
            unique case (state)
                ST_READ:  nxt = ST_READ;
                ST_WRITE: nxt = ST_WRITE;
                ST_DESEL: nxt = ST_DESEL;
                ST_SLEEP: nxt = ST_DESEL;
            endcase
        end else if (sel) begin
            nxt = wr_n ? ST_READ : ST_WRITE;
        end else begin
            nxt = ST_DESEL;
        end
    end

    // Burst base, beat counter and strobes captured with each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            bw_q   <= '1;
        end else if (clk_en) begin
            bw_q <= bw_n;
            if (!sleep && !adv && sel) begin
                base_q <= addr;
                beat_q <= 2'd0;
            end else if (!sleep && adv) begin
                beat_q <= beat_q + 2'd1;
            end
        end
    end

    // Outputs of the current command.
    always_comb begin
        cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat_q, burst_lin)};
        cur_bw_n = bw_q;
    end

endmodule

// File: rtl/nbt_late_wr.sv
module nbt_late_wr
    import nbt_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          pipe_mode,
    input  nbt_state_e    s1_state,
    input  logic [AW-1:0] s1_addr,
    input  logic [NB-1:0] s1_bw_n,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [NB-1:0] wr_mask,
    output logic          fwd_hit,
    output logic [NB-1:0] fwd_mask
);

    logic          s2_wr;
    logic [AW-1:0] s2_addr;
    logic [NB-1:0] s2_bw_n;

    // Second command stage, used by the double-late write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_bw_n <= '1;
        end else if (clk_en) begin
            s2_wr   <= (s1_state == ST_WRITE);
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end

    // The write whose data is on the bus at this edge.
    always_comb begin
        if (pipe_mode) begin
            wr_en   = clk_en && s2_wr;
            wr_addr = s2_addr;
            wr_mask = ~s2_bw_n;
        end else begin
            wr_en   = clk_en && (s1_state == ST_WRITE);
            wr_addr = s1_addr;
            wr_mask = ~s1_bw_n;
        end
        // Only the pipelined read can overtake a write that is not yet stored.
        fwd_hit  = pipe_mode && s2_wr && (s2_addr == s1_addr);
        fwd_mask = ~s2_bw_n;
    end

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
    parameter int AW     = 8,
    parameter int NB     = 2,
    parameter int BYTE_W = 9,
    localparam int DEPTH = 1 << AW,
    localparam int DW    = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NB-1:0] wmask,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g]) lane[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane[raddr];
    end

endmodule

// File: rtl/nbt_out_stage.sv
module nbt_out_stage #(
    parameter int NB     = 2,
    parameter int BYTE_W = 9,
    localparam int DW    = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic          s1_rd,
    input  logic [DW-1:0] arr_data,
    input  logic          fwd_hit,
    input  logic [NB-1:0] fwd_mask,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          pipe_v
);

    logic [DW-1:0] merged;
    logic [DW-1:0] pipe_d;

    // Byte merge of the write that is still in flight.
    for (genvar g = 0; g < NB; g++) begin : g_merge
        assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && fwd_mask[g])
                                          ? dq_in[g*BYTE_W +: BYTE_W]
                                          : arr_data[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pipe_v <= 1'b0;
        else if (clk_en) pipe_v <= s1_rd;
    end

    always_ff @(posedge clk) begin
        if (clk_en) pipe_d <= merged;
    end

    // Output enable and sleep act without a clock.
    always_comb begin
        dq_out = pipe_mode ? pipe_d : arr_data;
        dq_oe  = (pipe_mode ? pipe_v : s1_rd) && !oe_n && !sleep;
    end

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int AW     = 8,
    parameter int NB     = 2,
    parameter int BYTE_W = 9,
    localparam int DW    = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic [AW-1:0] addr,
    input  logic          adv,
    input  logic          wr_n,
    input  logic [NB-1:0] bw_n,
    input  logic          en_a_n,
    input  logic          en_b,
    input  logic          en_c_n,
    input  logic          burst_lin,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    logic          sel;
    nbt_state_e    s1_state;
    logic [AW-1:0] cur_addr;
    logic [NB-1:0] cur_bw_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [NB-1:0] wr_mask;
    logic          fwd_hit;
    logic [NB-1:0] fwd_mask;
    logic [DW-1:0] arr_data;
    logic          pipe_v;

    assign sel = !en_a_n && en_b && !en_c_n;

    nbt_burst_fsm #(.AW(AW), .NB(NB)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .sleep    (sleep),
        .adv      (adv),
        .wr_n     (wr_n),
        .sel      (sel),
        .burst_lin(burst_lin),
        .addr     (addr),
        .bw_n     (bw_n),
        .state    (s1_state),
        .cur_addr (cur_addr),
        .cur_bw_n (cur_bw_n)
    );

    nbt_late_wr #(.AW(AW), .NB(NB)) u_late (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .pipe_mode(pipe_mode),
        .s1_state (s1_state),
        .s1_addr  (cur_addr),
        .s1_bw_n  (cur_bw_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .fwd_hit  (fwd_hit),
        .fwd_mask (fwd_mask)
    );

    nbt_array #(.AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_arr (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wmask(wr_mask),
        .wdata(dq_in),
        .raddr(cur_addr),
        .rdata(arr_data)
    );

    nbt_out_stage #(.NB(NB), .BYTE_W(BYTE_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .pipe_mode(pipe_mode),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .s1_rd    (s1_state == ST_READ),
        .arr_data (arr_data),
        .fwd_hit  (fwd_hit),
        .fwd_mask (fwd_mask),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .pipe_v   (pipe_v)
    );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk
    import nbt_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          adv,
    input logic          en_a_n,
    input logic          en_b,
    input logic          en_c_n,
    input logic          pipe_mode,
    input logic          oe_n,
    input logic          sleep,
    input logic          dq_oe,
    input nbt_state_e    st,
    input logic [AW-1:0] cur_addr,
    input logic          wr_en,
    input logic          pipe_v
);

    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && !adv && !(!en_a_n && en_b && !en_c_n)) |=> (st == ST_DESEL));

    p_pipe_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && pipe_mode && st == ST_READ) |=> pipe_v);

    p_flow_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !pipe_mode && st == ST_WRITE) |-> wr_en);

    p_pipe_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && pipe_mode && $stable(pipe_mode) && $past(clk_en) && $past(st) == ST_WRITE) |-> wr_en);

    p_adv_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv && st == ST_WRITE) |=> (st == ST_WRITE));

    p_adv_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && adv && (st == ST_DESEL || st == ST_SLEEP)) |=> (st == ST_DESEL));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(st) && $stable(cur_addr)));

    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    p_sleep_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sleep) |=> (st == ST_SLEEP));

endmodule

bind nbt_sram nbt_sram_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .adv      (adv),
    .en_a_n   (en_a_n),
    .en_b     (en_b),
    .en_c_n   (en_c_n),
    .pipe_mode(pipe_mode),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .dq_oe    (dq_oe),
    .st       (s1_state),
    .cur_addr (cur_addr),
    .wr_en    (wr_en),
    .pipe_v   (pipe_v)
);

// File: tb/nbt_sram_bench.sv
`timescale 1ns/100ps
module nbt_sram_bench;

    localparam int AW    = 4;
    localparam int NB    = 2;
    localparam int DW    = NB * 9;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] CS_ON  = 3'b010;  // {en_c_n, en_b, en_a_n}
    localparam logic [2:0] CS_OFF = 3'b000;

    logic          clk = 1'b0;
    logic          rst_n, clk_en, adv, wr_n, en_a_n, en_b, en_c_n;
    logic          burst_lin, pipe_mode, oe_n, sleep, dq_oe;
    logic [AW-1:0] addr;
    logic [NB-1:0] bw_n;
    logic [DW-1:0] dq_in, dq_out;

    always #2.5 clk = ~clk;

    nbt_sram #(.AW(AW), .NB(NB)) u_nbt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .adv(adv),
        .wr_n(wr_n), .bw_n(bw_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_lin(burst_lin), .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int            n_chk = 0;
    int            n_fail = 0;
    int            cyc = 0;
    string         tag;
    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] din_d [8];
    bit            din_v [8];
    logic [DW-1:0] ed [8];
    bit            ev [8];
    int            bop;          // 0 none, 1 read, 2 write
    logic [AW-1:0] bbase;
    logic [1:0]    bcnt;

    task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [1:0] order(input logic [1:0] b, input logic [1:0] n, input logic lin);
        return lin ? 2'(b + n) : (b ^ n);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One enabled edge: drive the command, update the model, check outputs.
    task automatic cmd(input bit adv_i, input bit wrn_i, input logic [2:0] cs_i,
                       input logic [AW-1:0] a, input logic [NB-1:0] bwn,
                       input logic [DW-1:0] d);
        int lat = pipe_mode ? 2 : 1;
        int s = cyc % 8;
        int op = 0;
        logic [AW-1:0] ea = a;
        bit exp_oe;
        clk_en = 1'b1; adv = adv_i; wr_n = wrn_i;
        {en_c_n, en_b, en_a_n} = cs_i;
        addr = a; bw_n = bwn;
        dq_in = din_v[s] ? din_d[s] : (18'h2A5A5 ^ DW'(cyc * 77));
        din_v[s] = 1'b0;
        if (sleep) bop = 0;
        else if (adv_i) begin
            if (bop != 0) begin
                bcnt = bcnt + 2'd1;
                ea = {bbase[AW-1:2], order(bbase[1:0], bcnt, burst_lin)};
                op = bop;
            end
        end else if (cs_i == CS_ON) begin
            bop = wrn_i ? 1 : 2; bbase = a; bcnt = 2'd0; ea = a; op = bop;
        end else bop = 0;
        if (op == 1) begin
            ev[(cyc + lat - 1) % 8] = 1'b1;
            ed[(cyc + lat - 1) % 8] = mdl[ea];
        end
        if (op == 2) begin
            for (int i = 0; i < NB; i++)
                if (!bwn[i]) mdl[ea][9*i +: 9] = d[9*i +: 9];
            din_v[(cyc + lat) % 8] = 1'b1;
            din_d[(cyc + lat) % 8] = d;
        end
        tick();
        exp_oe = ev[s] && !oe_n && !sleep;
        check(tag, DW'(dq_oe), DW'(exp_oe));
        if (exp_oe) check(tag, dq_out, ed[s]);
        ev[s] = 1'b0;
        cyc++;
    endtask

    task automatic drain();
        repeat (3) cmd(1'b0, 1'b1, CS_OFF, '0, '1, '0);
    endtask

    // R9: a disabled edge with busy inputs must change nothing.
    task automatic stall();
        logic          p_oe = dq_oe;
        logic [DW-1:0] p_d  = dq_out;
        clk_en = 1'b0; adv = 1'b0; wr_n = 1'b0; {en_c_n, en_b, en_a_n} = CS_ON;
        addr = ~addr; bw_n = '0; dq_in = '1;
        tick();
        check("R9", DW'(dq_oe), DW'(p_oe));
        if (p_oe) check("R9", dq_out, p_d);
    endtask

    // Asynchronous output gating: which=1 output enable (R10), 0 sleep (R11).
    task automatic probe(input bit which, input string r);
        check(r, DW'(dq_oe), DW'(1));
        if (which) oe_n = 1'b1; else sleep = 1'b1;
        #0.5;
        check(r, DW'(dq_oe), DW'(0));
        oe_n = 1'b0; sleep = 1'b0;
        #0.5;
        check(r, DW'(dq_oe), DW'(1));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clk_en = 1'b1; adv = 1'b0; wr_n = 1'b1; bw_n = '1;
        {en_c_n, en_b, en_a_n} = CS_OFF; addr = '0; dq_in = '0;
        oe_n = 1'b0; sleep = 1'b0; bop = 0; bcnt = '0; bbase = '0;
        for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; din_v[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R12", DW'(dq_oe), DW'(0));
        tick();
        check("R12", DW'(dq_oe), DW'(0));
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL R12: watchdog expired, actual running expected finished");
        summary();
    end

    initial begin
        burst_lin = 1'b1;
        pipe_mode = 1'b0;
        for (int m = 0; m < 2; m++) begin
            pipe_mode = m[0];
            burst_lin = 1'b1;
            do_reset();

            // R2/R5: fill every word at full strobes.
            tag = "R2/R5";
            for (int a = 0; a < DEPTH; a++)
                cmd(1'b0, 1'b0, CS_ON, AW'(a), 2'b00, DW'(a * 1237 + m * 91 + 5));
            // R3 or R4: read every word back.
            tag = m ? "R4" : "R3";
            for (int a = 0; a < DEPTH; a++)
                cmd(1'b0, 1'b1, CS_ON, AW'(a), '1, '0);
            drain();

            // R7: write then read the same word on the next edge, no gaps.
            tag = "R7";
            for (int a = 0; a < DEPTH; a++) begin
                cmd(1'b0, 1'b0, CS_ON, AW'(a), 2'b00, DW'(a * 4099 + 3));
                cmd(1'b0, 1'b1, CS_ON, AW'(a), '1, '0);
                cmd(1'b0, 1'b1, CS_ON, AW'(a + 1), '1, '0);
            end
            drain();

            // R6: every strobe pattern into one word, read right after.
            tag = "R6";
            for (int k = 0; k < 4; k++) begin
                cmd(1'b0, 1'b0, CS_ON, AW'(3), NB'(k), DW'(18'h1F0E1 + k * 18'h2203));
                cmd(1'b0, 1'b1, CS_ON, AW'(3), '1, '0);
            end
            drain();

            // R8: four-beat bursts from each start offset, both orders.
            tag = "R8";
            for (int l = 0; l < 2; l++) begin
                burst_lin = l[0];
                for (int s = 0; s < 4; s++) begin
                    cmd(1'b0, 1'b0, CS_ON, AW'(8 + s), 2'b00, DW'(l * 300 + s * 40 + 1));
                    for (int b = 1; b < 4; b++)
                        cmd(1'b1, 1'b0, CS_OFF, '0, 2'b00, DW'(l * 300 + s * 40 + b * 7 + 1));
                    cmd(1'b0, 1'b1, CS_ON, AW'(8 + s), '1, '0);
                    for (int b = 1; b < 4; b++)
                        cmd(1'b1, 1'b1, CS_OFF, '0, '1, '0);
                end
                drain();
            end
            cmd(1'b0, 1'b1, CS_OFF, AW'(8), '1, '0);
            cmd(1'b1, 1'b1, CS_ON, '0, '1, '0);
            cmd(1'b1, 1'b0, CS_ON, '0, 2'b00, DW'(18'h3FFFF));
            drain();
            cmd(1'b0, 1'b1, CS_ON, AW'(8), '1, '0);
            drain();

            // R1: every chip-enable pattern for a write and for a read.
            tag = "R1";
            for (int c = 0; c < 8; c++) begin
                cmd(1'b0, 1'b0, 3'(c), AW'(5), 2'b00, DW'(18'h100 + c * 18'h1011));
                cmd(1'b0, 1'b1, 3'(c), AW'(5), '1, '0);
                cmd(1'b0, 1'b1, CS_ON, AW'(5), '1, '0);
            end
            drain();

            // R9: stalls between a write address and its data, and during a read.
            tag = "R9";
            cmd(1'b0, 1'b0, CS_ON, AW'(6), 2'b00, DW'(18'h2468A));
            stall();
            stall();
            cmd(1'b0, 1'b1, CS_ON, AW'(6), '1, '0);
            stall();
            cmd(1'b0, 1'b1, CS_OFF, '0, '1, '0);
            stall();
            drain();

            // R10: output enable gates the bus at once.
            tag = "R10";
            cmd(1'b0, 1'b1, CS_ON, AW'(2), '1, '0);
            if (m == 1) cmd(1'b0, 1'b1, CS_OFF, '0, '1, '0);
            probe(1'b1, "R10");
            drain();

            // R11: sleep gates the bus, blocks commands, keeps data.
            tag = "R11";
            cmd(1'b0, 1'b1, CS_ON, AW'(2), '1, '0);
            if (m == 1) cmd(1'b0, 1'b1, CS_OFF, '0, '1, '0);
            probe(1'b0, "R11");
            drain();
            sleep = 1'b1;
            cmd(1'b0, 1'b0, CS_ON, AW'(7), 2'b00, DW'(18'h0BEEF));
            cmd(1'b1, 1'b0, CS_ON, AW'(7), 2'b00, DW'(18'h0BEEF));
            sleep = 1'b0;
            cmd(1'b1, 1'b1, CS_ON, '0, '1, '0);
            cmd(1'b0, 1'b1, CS_ON, AW'(7), '1, '0);
            drain();
        end
        summary();
    end

endmodule